// File: doc/BRIEF.md
# Physical-Layer Symbol Framer with Gold-Code Scrambler

This block turns a queue of QPSK symbols into a continuous stream of physical-layer frames at one symbol per clock. Each frame opens with a header one slot long, 90 symbols wide. The header carries a fixed start-of-frame pattern followed by a coded signalling word. Both are BPSK modulated and both are supplied as parameters. The header is followed by the frame body.

When the header begins, the framer compares the queue occupancy against the size of one full payload. If enough symbols are waiting, the body is a data payload of `PAY_SLOTS` slots read from the queue in order. If not, the body is a dummy payload of `DUMMY_SLOTS` slots of unmodulated carrier, and the header carries the dummy signalling word instead.

Every body symbol is rotated by a complex scrambling code. The code is built from two degree-18 m-sequences and restarts at the first body symbol of every frame. The queue itself sits outside the block and is presented as a show-ahead head symbol, an occupancy count and a pop strobe.

Top module: `plf_framer`

## Requirements
- R1: A frame is one header slot of `SLOT_LEN` symbols followed by a body. `out_hdr` is high for exactly the header symbols. `out_start` is high only on the first header symbol.
- R2: Header symbol k, for k below `SOF_LEN`, carries bit `SOF_PAT[SOF_LEN-1-k]`. BPSK maps bit 0 to (+`AMP`,+`AMP`) and bit 1 to (−`AMP`,−`AMP`). Header symbols are never scrambled.
- R3: Header symbols `SOF_LEN` to `SLOT_LEN-1` carry the signalling word MSB first: `WORD_DATA` in a data frame, `WORD_DUMMY` in a dummy frame.
- R4: At the first header symbol, if `sym_avail` ≥ `PAY_SLOTS`·`SLOT_LEN`, the frame is a data frame. Its body is that many queued symbols in queue order. The frame kind then holds to the end of the frame.
- R5: Otherwise the frame is a dummy frame. Its body is `DUMMY_SLOTS`·`SLOT_LEN` symbols of (+`AMP`,+`AMP`) before scrambling, and `out_dummy` is high for the whole frame.
- R6: `sym_pop` is high exactly in the cycles in which a data-frame body symbol is taken. It is never high in a header or dummy body, so a frame consumes exactly one payload and never underflows the queue.
- R7: Scrambler x uses x(i+18)=x(i+7)⊕x(i), starting from x(0)=1 with the other stages 0. Scrambler y uses y(i+18)=y(i+10)⊕y(i7)⊕y(i+5)⊕y(i), starting from all ones. Body symbol n uses code Rn=2·zn+z'n, where zn=x(n)⊕y(n) and z'n is the XOR of x stages 4, 6, 15 and y stages 5, 6, 8 to 17. Rn rotates (I,Q) as follows: 0 gives (I,Q), 1 gives (−Q,I), 2 gives (−I,−Q), 3 gives (Q,−I). The index n restarts at 0 in every frame.
- R8: `out_valid` stays low in reset. It is high from the first clock after reset onward. The output symbol appears one clock after its source cycle.
- R9: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_avail | input | AVAIL_W | Number of symbols waiting in the external queue |
| sym_i | input | SYM_W | In-phase value of the queue head (signed) |
| sym_q | input | SYM_W | Quadrature value of the queue head (signed) |
| sym_pop | output | 1 | Takes the queue head in this cycle |
| out_valid | output | 1 | Output symbol valid |
| out_i | output | SYM_W | Output in-phase value (signed) |
| out_q | output | SYM_W | Output quadrature value (signed) |
| out_hdr | output | 1 | Output symbol belongs to a header |
| out_start | output | 1 | First symbol of a frame |
| out_dummy | output | 1 | Output symbol belongs to a dummy frame |

## Verification
The bench builds the framer with `PAY_SLOTS`=6 and `DUMMY_SLOTS`=2, keeping the 90-symbol slot. A data frame is then 630 symbols and a dummy frame 270, so six frames fit in a short run. Those six frames cover an empty queue at start-up, a queue with spare symbols, and a queue that is exactly one symbol short. They also cover a queue filled to the exact threshold and a queue emptied back to zero. Every frame restarts the scrambler, so the rotations of the first few hundred code values are compared many times over, in both dummy and data bodies.

// File: rtl/plf_pkg.sv
package plf_pkg;

    // Which part of a frame the framer is producing.
    typedef enum logic {
        SEG_HDR  = 1'b0,
        SEG_BODY = 1'b1
    } seg_e;

    // Scrambler register length and start values.
    localparam int           GOLD_LEN = 18;
    localparam logic [17:0]  X_SEED   = 18'h00001;
    localparam logic [17:0]  Y_SEED   = 18'h3FFFF;

endpackage

// File: rtl/plf_slot_counter.sv
module plf_slot_counter #(
    parameter int SLOT_LEN  = 90,
    parameter int MAX_SLOTS = 360,
    parameter int IDX_W     = $clog2(SLOT_LEN),
    parameter int SLOT_W    = $clog2(MAX_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] seg_slots,
    output logic [IDX_W-1:0]  sym_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              seg_first,
    output logic              seg_last
);

    typedef struct packed {
        logic [IDX_W-1:0]  sym;
        logic [SLOT_W-1:0] slot;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic slot_end;

    always_comb begin
        slot_end  = (cnt_q.sym == IDX_W'(SLOT_LEN - 1));
        seg_last  = slot_end && (cnt_q.slot == (seg_slots - 1'b1));
        seg_first = (cnt_q.sym == '0) && (cnt_q.slot == '0);
        cnt_d     = cnt_q;
        if (seg_last) begin
            cnt_d = '0;
        end else if (slot_end) begin
            cnt_d.sym  = '0;
            cnt_d.slot = cnt_q.slot + 1'b1;
        end else begin
            cnt_d.sym = cnt_q.sym + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sym_idx  = cnt_q.sym;
    assign slot_idx = cnt_q.slot;

    // R1: the symbol index never leaves the slot
    p_sym_in_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.sym < IDX_W'(SLOT_LEN));

    // R1: the slot index stays inside the current segment
    p_slot_in_seg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.slot < seg_slots);

endmodule

// File: rtl/plf_gold_scrambler.sv
module plf_gold_scrambler
    import plf_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    advance,
    input  logic signed [SYM_W-1:0] in_i,
    input  logic signed [SYM_W-1:0] in_q,
    output logic signed [SYM_W-1:0] out_i,
    output logic signed [SYM_W-1:0] out_q
);

    typedef struct packed {
        logic [GOLD_LEN-1:0] x;
        logic [GOLD_LEN-1:0] y;
    } gold_t;

    gold_t st_d, st_q;
    logic  z_main, z_side;
    logic [1:0] rn;

    always_comb begin
        z_main = st_q.x[0] ^ st_q.y[0];
        z_side = st_q.x[4] ^ st_q.x[6] ^ st_q.x[15]
               ^ st_q.y[5] ^ st_q.y[6] ^ (^st_q.y[17:8]);
        rn     = {z_main, z_side};

        unique case (rn)
            2'd0: begin out_i = in_i;  out_q = in_q;  end
            2'd1: begin out_i = -in_q; out_q = in_i;  end
            2'd2: begin out_i = -in_i; out_q = -in_q; end
            default: begin out_i = in_q; out_q = -in_i; end
        endcase

        st_d = st_q;
        if (restart) begin
            st_d.x = X_SEED;
            st_d.y = Y_SEED;
        end else if (advance) begin
            st_d.x = {st_q.x[7] ^ st_q.x[0], st_q.x[GOLD_LEN-1:1]};
            st_d.y = {st_q.y[10] ^ st_q.y[7] ^ st_q.y[5] ^ st_q.y[0],
                      st_q.y[GOLD_LEN-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.x <= X_SEED;
            st_q.y <= Y_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a restart request leaves both registers at their seeds
    p_restart_seeds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.x == X_SEED) && (st_q.y == Y_SEED));

    // R7: the m-sequence registers never fall into the all-zero lock-up state
    p_no_lockup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.x != '0) && (st_q.y != '0));

endmodule

// File: rtl/plf_hdr_gen.sv
module plf_hdr_gen #(
    parameter int              SLOT_LEN   = 90,
    parameter int              SOF_LEN    = 26,
    parameter int              WORD_LEN   = 64,
    parameter logic [25:0]     SOF_PAT    = 26'h18D2E82,
    parameter logic [63:0]     WORD_DATA  = 64'h0,
    parameter logic [63:0]     WORD_DUMMY = 64'h0,
    parameter int              SYM_W      = 8,
    parameter int              AMP        = 90,
    parameter int              IDX_W      = $clog2(SLOT_LEN)
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic                    dummy,
    output logic signed [SYM_W-1:0] hdr_i,
    output logic signed [SYM_W-1:0] hdr_q
);

    localparam logic signed [SYM_W-1:0] POS = SYM_W'(AMP);
    localparam logic signed [SYM_W-1:0] NEG = -SYM_W'(AMP);

    logic [WORD_LEN-1:0] word;
    logic                bit_v;
    int                  k;

    always_comb begin
        word = dummy ? WORD_DUMMY[WORD_LEN-1:0] : WORD_DATA[WORD_LEN-1:0];
        k    = int'(idx);
        if (k < SOF_LEN) bit_v = SOF_PAT[SOF_LEN - 1 - k];
        else             bit_v = word[WORD_LEN - 1 - (k - SOF_LEN)];
        hdr_i = bit_v ? NEG : POS;
        hdr_q = bit_v ? NEG : POS;
    end

endmodule

// File: rtl/plf_framer.sv
module plf_framer
    import plf_pkg::*;
#(
    parameter int          SLOT_LEN    = 90,
    parameter int          SOF_LEN     = 26,
    parameter int          WORD_LEN    = 64,
    parameter int          PAY_SLOTS   = 360,
    parameter int          DUMMY_SLOTS = 36,
    parameter int          SYM_W       = 8,
    parameter int          AMP         = 90,
    parameter int          AVAIL_W     = 16,
    parameter logic [25:0] SOF_PAT     = 26'h18D2E82,
    parameter logic [63:0] WORD_DATA   = 64'h9C3A_51E7_06BD_F248,
    parameter logic [63:0] WORD_DUMMY  = 64'h33CC_0FF0_A55A_6996
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AVAIL_W-1:0]      sym_avail,
    input  logic signed [SYM_W-1:0] sym_i,
    input  logic signed [SYM_W-1:0] sym_q,
    output logic                    sym_pop,
    output logic                    out_valid,
    output logic signed [SYM_W-1:0] out_i,
    output logic signed [SYM_W-1:0] out_q,
    output logic                    out_hdr,
    output logic                    out_start,
    output logic                    out_dummy
);

    localparam int MAX_SLOTS = (PAY_SLOTS > DUMMY_SLOTS) ? PAY_SLOTS : DUMMY_SLOTS;
    localparam int IDX_W     = $clog2(SLOT_LEN);
    localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);
    localparam int FULL_SYMS = PAY_SLOTS * SLOT_LEN;
    localparam logic signed [SYM_W-1:0] AMP_V = SYM_W'(AMP);

    typedef struct packed {
        seg_e                    seg;
        logic                    full;
        logic                    valid;
        logic signed [SYM_W-1:0] oi;
        logic signed [SYM_W-1:0] oq;
        logic                    hdr;
        logic                    start;
        logic                    dummy;
    } frm_t;

    frm_t st_d, st_q;

    logic [IDX_W-1:0]        sym_idx;
    logic [SLOT_W-1:0]       slot_idx;
    logic [SLOT_W-1:0]       seg_slots;
    logic                    seg_first, seg_last;
    logic                    hdr_first, full_now;
    logic                    scr_restart, scr_advance;
    logic signed [SYM_W-1:0] scr_in_i, scr_in_q, scr_out_i, scr_out_q;
    logic signed [SYM_W-1:0] hdr_i, hdr_q;

    plf_slot_counter #(
        .SLOT_LEN (SLOT_LEN),
        .MAX_SLOTS(MAX_SLOTS),
        .IDX_W    (IDX_W),
        .SLOT_W   (SLOT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .seg_slots(seg_slots),
        .sym_idx  (sym_idx),
        .slot_idx (slot_idx),
        .seg_first(seg_first),
        .seg_last (seg_last)
    );

    plf_hdr_gen #(
        .SLOT_LEN  (SLOT_LEN),
        .SOF_LEN   (SOF_LEN),
        .WORD_LEN  (WORD_LEN),
        .SOF_PAT   (SOF_PAT),
        .WORD_DATA (WORD_DATA),
        .WORD_DUMMY(WORD_DUMMY),
        .SYM_W     (SYM_W),
        .AMP       (AMP),
        .IDX_W     (IDX_W)
    ) u_hdr (
        .idx  (sym_idx),
        .dummy(!full_now),
        .hdr_i(hdr_i),
        .hdr_q(hdr_q)
    );

    plf_gold_scrambler #(
        .SYM_W(SYM_W)
    ) u_scr (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(scr_restart),
        .advance(scr_advance),
        .in_i   (scr_in_i),
        .in_q   (scr_in_q),
        .out_i  (scr_out_i),
        .out_q  (scr_out_q)
    );

    always_comb begin
        hdr_first = (st_q.seg == SEG_HDR) && seg_first;
        full_now  = hdr_first ? (32'(sym_avail) >= FULL_SYMS) : st_q.full;

        if (st_q.seg == SEG_HDR) seg_slots = SLOT_W'(1);
        else if (full_now)       seg_slots = SLOT_W'(PAY_SLOTS);
        else                     seg_slots = SLOT_W'(DUMMY_SLOTS);

        sym_pop     = (st_q.seg == SEG_BODY) && full_now;
        scr_in_i    = sym_pop ? sym_i : AMP_V;
        scr_in_q    = sym_pop ? sym_q : AMP_V;
        scr_restart = (st_q.seg == SEG_HDR);
        scr_advance = (st_q.seg == SEG_BODY);

        st_d       = st_q;
        st_d.full  = full_now;
        st_d.valid = 1'b1;
        st_d.dummy = !full_now;
        if (st_q.seg == SEG_HDR) begin
            st_d.oi    = hdr_i;
            st_d.oq    = hdr_q;
            st_d.hdr   = 1'b1;
            st_d.start = hdr_first;
        end else begin
            st_d.oi    = scr_out_i;
            st_d.oq    = scr_out_q;
            st_d.hdr   = 1'b0;
            st_d.start = 1'b0;
        end
        if (seg_last) st_d.seg = (st_q.seg == SEG_HDR) ? SEG_BODY : SEG_HDR;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_i     = st_q.oi;
    assign out_q     = st_q.oq;
    assign out_hdr   = st_q.hdr;
    assign out_start = st_q.start;
    assign out_dummy = st_q.dummy;

    // R6: a pop is only issued while the queue reports data
    p_pop_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_pop |-> (sym_avail != '0));

    // R1: every header on the output begins with the frame-start marker
    p_hdr_opens_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_hdr) |-> out_start);

    // R8: once valid, the output stays valid
    p_valid_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    // R4: the frame kind cannot change inside a body
    p_kind_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seg == SEG_BODY) |-> $stable(st_q.full));

endmodule

// File: tb/plf_framer_test.sv
module plf_framer_test;

    localparam int SLOT  = 90;
    localparam int PAY   = 6;
    localparam int DUM   = 2;
    localparam int AMP   = 90;
    localparam int FULLN = PAY * SLOT;
    localparam int NPAY  = 1080;
    localparam logic [25:0] SOF  = 26'h18D2E82;
    localparam logic [63:0] WDAT = 64'hA5C3_0F96_3CE1_7B24;
    localparam logic [63:0] WDUM = 64'h5B1E_C0F3_96A7_2D48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] sym_avail = '0;
    logic signed [7:0] sym_i = '0, sym_q = '0;
    logic sym_pop, out_valid, out_hdr, out_start, out_dummy;
    logic signed [7:0] out_i, out_q;

    always #2 clk = ~clk;

    plf_framer #(
        .SLOT_LEN(SLOT), .SOF_LEN(26), .WORD_LEN(64), .PAY_SLOTS(PAY),
        .DUMMY_SLOTS(DUM), .SYM_W(8), .AMP(AMP), .AVAIL_W(16),
        .SOF_PAT(SOF), .WORD_DATA(WDAT), .WORD_DUMMY(WDUM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sym_avail(sym_avail), .sym_i(sym_i),
        .sym_q(sym_q), .sym_pop(sym_pop), .out_valid(out_valid),
        .out_i(out_i), .out_q(out_q), .out_hdr(out_hdr),
        .out_start(out_start), .out_dummy(out_dummy)
    );

    typedef struct {
        logic signed [7:0] i;
        logic signed [7:0] q;
        bit hdr;
        bit start;
        bit dummy;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    logic [15:0] fifo[$];
    logic signed [7:0] pay_i[NPAY];
    logic signed [7:0] pay_q[NPAY];
    int checks = 0, errors = 0;
    int feed_idx = 0, pops = 0, pay_used = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit hdr_bit(input int k, input bit dmy);
        if (k < 26) return SOF[25 - k];
        return dmy ? WDUM[63 - (k - 26)] : WDAT[63 - (k - 26)];
    endfunction

    // Expected frame, built from the requirements.
    task automatic plan_frame(input bit full);
        exp_t e;
        logic [17:0] x = 18'h00001;
        logic [17:0] y = 18'h3FFFF;
        logic signed [7:0] si, sq;
        logic [1:0] rn;
        int nbody = full ? FULLN : DUM * SLOT;
        for (int k = 0; k < SLOT; k++) begin
            e.i = hdr_bit(k, !full) ? -8'sd90 : 8'sd90;
            e.q = e.i;
            e.hdr = 1'b1; e.start = (k == 0); e.dummy = !full;
            e.tag = (k < 26) ? "R2 sof" : "R3 word";
            exp_q.push_back(e);
        end
        for (int n = 0; n < nbody; n++) begin
            if (full) begin si = pay_i[pay_used]; sq = pay_q[pay_used]; pay_used++; end
            else begin si = 8'sd90; sq = 8'sd90; end
            rn = {x[0] ^ y[0], x[4] ^ x[6] ^ x[15] ^ y[5] ^ y[6] ^ (^y[17:8])};
            case (rn)
                2'd0: begin e.i = si;  e.q = sq;  end
                2'd1: begin e.i = -sq; e.q = si;  end
                2'd2: begin e.i = -si; e.q = -sq; end
                default: begin e.i = sq; e.q = -si; end
            endcase
            e.hdr = 1'b0; e.start = 1'b0; e.dummy = !full;
            e.tag = full ? "R4,R7 data body" : "R5,R7 dummy body";
            exp_q.push_back(e);
            x = {x[7] ^ x[0], x[17:1]};
            y = {y[10] ^ y[7] ^ y[5] ^ y[0], y[17:1]};
        end
    endtask

    task automatic feed(input int n);
        for (int k = 0; k < n; k++) begin
            fifo.push_back({pay_i[feed_idx], pay_q[feed_idx]});
            feed_idx++;
        end
    endtask

    initial begin
        exp_t e;
        bit pop_now;
        int cyc;
        for (int k = 0; k < NPAY; k++) begin
            pay_i[k] = 8'((k * 37 + 5) % 255 - 127);
            pay_q[k] = 8'((k * 53 + 11) % 255 - 127);
        end
        // frame kinds: empty, 560 queued, 20 left, 539 queued, 540 queued, empty
        plan_frame(1'b0);
        plan_frame(1'b1);
        plan_frame(1'b0);
        plan_frame(1'b0);
        plan_frame(1'b1);
        plan_frame(1'b0);

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9 valid in reset", out_valid, 0);
        check(out_i == 0 && out_q == 0, "R9 data in reset", out_i, 0);
        check({out_hdr, out_start, out_dummy} == 3'b000, "R9 flags in reset",
              {out_hdr, out_start, out_dummy}, 0);
        check(out_valid == 1'b0, "R8 valid low in reset", out_valid, 0);
        rst_n = 1'b1;

        cyc = 0;
        while (exp_q.size() > 0) begin
            @(negedge clk);
            // monitor
            check(out_valid == 1'b1, "R8 valid after reset", out_valid, 1);
            if (out_valid) begin
                e = exp_q.pop_front();
                check(out_i == e.i, {e.tag, " I"}, out_i, e.i);
                check(out_q == e.q, {e.tag, " Q"}, out_q, e.q);
                check(out_hdr == e.hdr && out_start == e.start, "R1 header flags",
                      {out_hdr, out_start}, {e.hdr, e.start});
                check(out_dummy == e.dummy, "R5 dummy flag", out_dummy, e.dummy);
            end
            // driver
            pop_now = sym_pop;
            if (pop_now) check(fifo.size() > 0, "R6 pop on empty queue", fifo.size(), 1);
            if (cyc == 100)  feed(560);
            if (cyc == 1000) feed(519);
            if (cyc == 1270) feed(1);
            @(posedge clk);
            #1;
            if (pop_now && fifo.size() > 0) begin
                void'(fifo.pop_front());
                pops++;
            end
            sym_avail = 16'(fifo.size());
            if (fifo.size() > 0) begin
                sym_i = fifo[0][15:8];
                sym_q = fifo[0][7:0];
            end else begin
                sym_i = '0;
                sym_q = '0;
            end
            cyc++;
            if (cyc > 10000) begin
                check(1'b0, "watchdog", cyc, 2340);
                break;
            end
        end
        // R6: exactly two payloads consumed, queue drained
        check(pops == 2 * FULLN, "R6 total pops", pops, 2 * FULLN);
        check(fifo.size() == 0, "R4 queue drained", fifo.size(), 0);
        check(sym_pop == 1'b0, "R6 no pop in dummy header", sym_pop, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule